// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, cycle by cycle, which hardware thread of a multi-context core may fetch. Every thread owns a private program counter held inside the block, so moving fetch from one thread to another costs nothing: there is no state to save or restore. Each cycle the block takes a ready flag and a long-stall flag from every thread. It drives a one-hot grant and a valid flag, and it presents the index and the program counter of the chosen thread.

A single mode input selects the policy. In fine-grained mode the grant rotates round-robin over the ready threads, so the fetching thread changes every cycle whenever there is a choice. In coarse-grained mode the current thread keeps fetch until it drops ready or reports a costly stall, such as a miss in the second-level cache. Fetch then moves to the next eligible thread in rotating order. Each grant advances the chosen thread's program counter by the fetch width. A redirect port loads a new target into any thread's counter, and a redirect wins over the advance on the same edge.

Top module: `fts_thread_sel`

## Requirements
- R1: At most one bit of `grant` is set. `fetch_valid` is high exactly when a bit is set, and the set bit is bit number `fetch_tid`.
- R2: When no thread is eligible, `grant` is all zeros and `fetch_valid` is low. Eligible means ready in fine mode (`coarse_mode`=0), and ready with stall low in coarse mode (`coarse_mode`=1).
- R3: In fine mode the grant goes to the first ready thread found by scanning upward from the thread after the last granted one, wrapping from NUM_THREADS-1 to 0.
- R4: In fine mode, when two or more threads are ready and a grant was made in the previous cycle, the granted thread differs from the previous one.
- R5: In coarse mode, a thread granted in the previous cycle is granted again while it stays ready with stall low.
- R6: In coarse mode a thread with stall high is never granted. When the held thread becomes ineligible, the grant moves to the next eligible thread in the rotating order of R3.
- R7: `fetch_pc` shows the granted thread's counter. Each grant adds FETCH_BYTES to that counter on the clock edge, modulo 2^PC_W.
- R8: A redirect (`redir_valid`=1) loads `redir_pc` into thread `redir_tid` on the clock edge. This overrides the advance if that thread is granted in the same cycle.
- R9: After reset every counter holds RESET_PC, and the scan for the first grant starts at thread 0.
- R10: A thread that is neither granted nor redirected keeps its counter unchanged.
- R11: In fine mode the stall inputs have no effect on the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coarse_mode | input | 1 | 0 = rotate every cycle, 1 = hold until stall |
| thread_ready | input | NUM_THREADS | Per-thread ready to fetch |
| thread_stall | input | NUM_THREADS | Per-thread costly-stall indication |
| redir_valid | input | 1 | Load a new PC into one thread |
| redir_tid | input | TID_W | Thread targeted by the redirect |
| redir_pc | input | PC_W | Redirect target |
| grant | output | NUM_THREADS | One-hot fetch grant |
| fetch_valid | output | 1 | A thread is granted this cycle |
| fetch_tid | output | TID_W | Index of the granted thread |
| fetch_pc | output | PC_W | PC of the granted thread |

## Verification
The bench builds the block with four threads, a 12-bit PC and a 16-byte fetch width. Four threads are enough to produce rotations that skip threads that are not adjacent, and coarse-mode switches that wrap past the top index. The narrow PC lets one thread held in coarse mode wrap its counter within 256 grants, so the modulo advance is exercised in a short run.

// File: rtl/fts_pkg.sv
// Shared types for the fetch thread selector.
// Assumes: nothing beyond IEEE 1800-2017.
package fts_pkg;

    // Selection policy driven by the coarse_mode pin
    typedef enum logic {
        FTS_FINE   = 1'b0,
        FTS_COARSE = 1'b1
    } fts_mode_e;

endpackage

// File: rtl/fts_rr_pick.sv
// Rotating-priority picker: finds the first set request scanning upward
// from `start`, wrapping at NUM_THREADS-1.
// Assumes: start < NUM_THREADS.
module fts_rr_pick #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0] req,
    input  logic [TID_W-1:0]       start,
    output logic                   found,
    output logic [TID_W-1:0]       idx
);

    // Scan all positions in rotated order, keep the first hit
    always_comb begin
        int pos;
        pos   = 0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            pos = (int'(start) + i) % NUM_THREADS;
            if (!found && req[pos]) begin
                found = 1'b1;
                idx   = TID_W'(pos);
            end
        end
    end

endmodule

// File: rtl/fts_policy.sv
// Policy state: remembers the last granted thread, builds the eligible
// mask for the current mode, and decides whether coarse mode holds the
// current thread. Gives the scan start for the rotating picker.
// Assumes: commit_valid/commit_tid describe the grant actually issued.
module fts_policy
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  fts_mode_e              mode,
    input  logic [NUM_THREADS-1:0] thread_ready,
    input  logic [NUM_THREADS-1:0] thread_stall,
    input  logic                   commit_valid,
    input  logic [TID_W-1:0]       commit_tid,
    output logic [NUM_THREADS-1:0] eligible,
    output logic                   hold,
    output logic [TID_W-1:0]       hold_tid,
    output logic [TID_W-1:0]       scan_start
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    logic [TID_W-1:0] cur_q;
    logic             have_q;

    // Track the last granted thread; reset points at the top so scan starts at 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= LAST_TID;
            have_q <= 1'b0;
        end else if (commit_valid) begin
            cur_q  <= commit_tid;
            have_q <= 1'b1;
        end
    end

    // Eligibility: stall only masks threads in coarse mode
    always_comb begin
        if (mode == FTS_COARSE) eligible = thread_ready & ~thread_stall;
        else                    eligible = thread_ready;
    end

    // Coarse hold on the current thread, and rotated scan start
    always_comb begin
        hold       = (mode == FTS_COARSE) && have_q && eligible[cur_q];
        hold_tid   = cur_q;
        scan_start = (cur_q == LAST_TID) ? '0 : cur_q + 1'b1;
    end

endmodule

// File: rtl/fts_pc_bank.sv
// Per-thread program counter registers. A redirect loads a target and
// has priority over the fetch advance; the read port follows rd_tid.
// Assumes: adv_tid and redir_tid are below NUM_THREADS.
module fts_pc_bank #(
    parameter int              NUM_THREADS = 4,
    parameter int              TID_W       = 2,
    parameter int              PC_W        = 32,
    parameter int              FETCH_BYTES = 16,
    parameter logic [PC_W-1:0] RESET_PC    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_valid,
    input  logic [TID_W-1:0] adv_tid,
    input  logic             redir_valid,
    input  logic [TID_W-1:0] redir_tid,
    input  logic [PC_W-1:0]  redir_pc,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(FETCH_BYTES);

    logic [NUM_THREADS-1:0][PC_W-1:0] pc_all;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctx
        logic [PC_W-1:0] pc_q;

        // One context counter: redirect first, then advance on grant
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q <= RESET_PC;
            end else if (redir_valid && redir_tid == TID_W'(t)) begin
                pc_q <= redir_pc;
            end else if (adv_valid && adv_tid == TID_W'(t)) begin
                pc_q <= pc_q + STEP;
            end
        end

        assign pc_all[t] = pc_q;
    end

    // Read mux for the granted thread
    always_comb begin
        rd_pc = pc_all[rd_tid];
    end

endmodule

// File: rtl/fts_thread_sel.sv
// Fetch thread selector top. Combines the policy state, the rotating
// picker and the PC bank; grant and PC are combinational from the current
// state and inputs, and state updates on the clock edge.
// Assumes: NUM_THREADS >= 2; synchronous active-low reset.
module fts_thread_sel
    import fts_pkg::*;
#(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter int              FETCH_BYTES = 16,
    parameter logic [PC_W-1:0] RESET_PC    = '0,
    localparam int             TID_W       = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   coarse_mode,
    input  logic [NUM_THREADS-1:0] thread_ready,
    input  logic [NUM_THREADS-1:0] thread_stall,
    input  logic                   redir_valid,
    input  logic [TID_W-1:0]       redir_tid,
    input  logic [PC_W-1:0]        redir_pc,
    output logic [NUM_THREADS-1:0] grant,
    output logic                   fetch_valid,
    output logic [TID_W-1:0]       fetch_tid,
    output logic [PC_W-1:0]        fetch_pc
);

    fts_mode_e              mode;
    logic [NUM_THREADS-1:0] eligible;
    logic                   hold;
    logic [TID_W-1:0]       hold_tid;
    logic [TID_W-1:0]       scan_start;
    logic                   scan_found;
    logic [TID_W-1:0]       scan_idx;

    assign mode = fts_mode_e'(coarse_mode);

    fts_policy #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_policy (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .thread_ready (thread_ready),
        .thread_stall (thread_stall),
        .commit_valid (fetch_valid),
        .commit_tid   (fetch_tid),
        .eligible     (eligible),
        .hold         (hold),
        .hold_tid     (hold_tid),
        .scan_start   (scan_start)
    );

    fts_rr_pick #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_pick (
        .req   (eligible),
        .start (scan_start),
        .found (scan_found),
        .idx   (scan_idx)
    );

    // Final choice: coarse hold wins over a fresh scan
    always_comb begin
        fetch_valid = hold | scan_found;
        fetch_tid   = hold ? hold_tid : scan_idx;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_grant
        assign grant[t] = fetch_valid && (fetch_tid == TID_W'(t));
    end

    fts_pc_bank #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W),
        .PC_W        (PC_W),
        .FETCH_BYTES (FETCH_BYTES),
        .RESET_PC    (RESET_PC)
    ) u_pcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_valid   (fetch_valid),
        .adv_tid     (fetch_tid),
        .redir_valid (redir_valid),
        .redir_tid   (redir_tid),
        .redir_pc    (redir_pc),
        .rd_tid      (fetch_tid),
        .rd_pc       (fetch_pc)
    );

endmodule

// File: rtl/fts_checker.sv
// Property checker for fts_thread_sel, attached by bind below.
// Assumes: observes top-level ports only.
module fts_checker #(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    parameter int FETCH_BYTES = 16,
    parameter int TID_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   coarse_mode,
    input logic [NUM_THREADS-1:0] thread_ready,
    input logic [NUM_THREADS-1:0] thread_stall,
    input logic                   redir_valid,
    input logic [TID_W-1:0]       redir_tid,
    input logic [PC_W-1:0]        redir_pc,
    input logic [NUM_THREADS-1:0] grant,
    input logic                   fetch_valid,
    input logic [TID_W-1:0]       fetch_tid,
    input logic [PC_W-1:0]        fetch_pc
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R1

    AST_VALID_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> grant[fetch_tid]); // R1

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_ready == '0) |-> (!fetch_valid && grant == '0)); // R2

    AST_GRANT_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> thread_ready[fetch_tid]); // R3

    AST_FINE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_valid) && !coarse_mode
         && $countones(thread_ready) > 1)
        |-> fetch_tid != $past(fetch_tid)); // R4

    AST_COARSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_valid) && coarse_mode
         && thread_ready[$past(fetch_tid)] && !thread_stall[$past(fetch_tid)])
        |-> (fetch_valid && fetch_tid == $past(fetch_tid))); // R5

    AST_COARSE_NO_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_mode && fetch_valid) |-> !thread_stall[fetch_tid]); // R6

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_valid) && !$past(redir_valid)
         && fetch_valid && fetch_tid == $past(fetch_tid))
        |-> fetch_pc == $past(fetch_pc) + PC_W'(FETCH_BYTES)); // R7

    AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(redir_valid) && fetch_valid
         && fetch_tid == $past(redir_tid))
        |-> fetch_pc == $past(redir_pc)); // R8

endmodule

bind fts_thread_sel fts_checker #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .FETCH_BYTES (FETCH_BYTES),
    .TID_W       (TID_W)
) u_fts_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .coarse_mode  (coarse_mode),
    .thread_ready (thread_ready),
    .thread_stall (thread_stall),
    .redir_valid  (redir_valid),
    .redir_tid    (redir_tid),
    .redir_pc     (redir_pc),
    .grant        (grant),
    .fetch_valid  (fetch_valid),
    .fetch_tid    (fetch_tid),
    .fetch_pc     (fetch_pc)
);

// File: tb/fts_thread_sel_tb_top.sv
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// outcome from the requirements and queues it; the monitor compares at the
// falling edge.
module fts_thread_sel_tb_top;

    localparam int NT  = 4;
    localparam int PW  = 12;
    localparam int INC = 16;
    localparam int TW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coarse_mode = 1'b0;
    logic [NT-1:0] thread_ready = '0;
    logic [NT-1:0] thread_stall = '0;
    logic          redir_valid = 1'b0;
    logic [TW-1:0] redir_tid = '0;
    logic [PW-1:0] redir_pc = '0;
    logic [NT-1:0] grant;
    logic          fetch_valid;
    logic [TW-1:0] fetch_tid;
    logic [PW-1:0] fetch_pc;

    always #4 clk = ~clk; // 125 MHz

    fts_thread_sel #(
        .NUM_THREADS (NT),
        .PC_W        (PW),
        .FETCH_BYTES (INC),
        .RESET_PC    ('0)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .coarse_mode  (coarse_mode),
        .thread_ready (thread_ready),
        .thread_stall (thread_stall),
        .redir_valid  (redir_valid),
        .redir_tid    (redir_tid),
        .redir_pc     (redir_pc),
        .grant        (grant),
        .fetch_valid  (fetch_valid),
        .fetch_tid    (fetch_tid),
        .fetch_pc     (fetch_pc)
    );

    typedef struct {
        bit            v;
        int            tid;
        logic [PW-1:0] pc;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // Reference state from the requirements
    logic [PW-1:0] m_pc [NT];
    int            m_cur = 0;
    bit            m_have = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, predict and queue the expected result
    task automatic step(input logic [NT-1:0] rdy, input logic [NT-1:0] stl,
                        input logic crs, input logic rv, input int rt,
                        input logic [PW-1:0] rpc, input string tag);
        exp_t e;
        logic [NT-1:0] elig;
        int start;
        @(posedge clk);
        #1;
        thread_ready = rdy;
        thread_stall = stl;
        coarse_mode  = crs;
        redir_valid  = rv;
        redir_tid    = TW'(rt);
        redir_pc     = rpc;
        elig  = crs ? (rdy & ~stl) : rdy;
        e.v   = 0;
        e.tid = 0;
        e.pc  = '0;
        e.tag = tag;
        if (elig != '0) begin
            e.v = 1;
            if (crs && m_have && elig[m_cur]) begin
                e.tid = m_cur;
            end else begin
                start = m_have ? (m_cur + 1) % NT : 0;
                for (int i = NT - 1; i >= 0; i--)
                    if (elig[(start + i) % NT]) e.tid = (start + i) % NT;
            end
            e.pc = m_pc[e.tid];
        end
        sb_q.push_back(e);
        if (e.v) begin
            m_pc[e.tid] = m_pc[e.tid] + PW'(INC);
            m_cur  = e.tid;
            m_have = 1;
        end
        if (rv) m_pc[rt] = rpc;
    endtask

    task automatic go(input logic [NT-1:0] rdy, input logic [NT-1:0] stl,
                      input logic crs, input string tag);
        step(rdy, stl, crs, 1'b0, 0, '0, tag);
    endtask

    // Monitor: compare outputs against queued predictions
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(fetch_valid == e.v, e.tag, "fetch_valid", int'(fetch_valid), int'(e.v));
                chk(grant == (e.v ? NT'(1) << e.tid : NT'(0)), "R1", "grant",
                    int'(grant), e.v ? (1 << e.tid) : 0);
                if (e.v) begin
                    chk(int'(fetch_tid) == e.tid, e.tag, "fetch_tid", int'(fetch_tid), e.tid);
                    chk(fetch_pc == e.pc, e.tag, "fetch_pc", int'(fetch_pc), int'(e.pc));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        for (int t = 0; t < NT; t++) m_pc[t] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: first grant scans from thread 0, PCs at reset value
        go(4'b1111, 4'b0000, 1'b0, "R9");
        // R3 / R4: full rotation, PC advance R7
        for (int i = 0; i < 6; i++) go(4'b1111, 4'b0000, 1'b0, "R4");
        // R3: sparse ready set skips threads
        for (int i = 0; i < 4; i++) go(4'b1010, 4'b0000, 1'b0, "R3");
        go(4'b0001, 4'b0000, 1'b0, "R3");
        go(4'b0001, 4'b0000, 1'b0, "R3");
        go(4'b1100, 4'b0000, 1'b0, "R3");
        // R11: stall ignored in fine mode
        go(4'b1111, 4'b1111, 1'b0, "R11");
        go(4'b1111, 4'b0101, 1'b0, "R11");
        go(4'b0110, 4'b0110, 1'b0, "R11");
        // R2: no ready thread
        go(4'b0000, 4'b0000, 1'b0, "R2");
        go(4'b0000, 4'b1111, 1'b1, "R2");
        go(4'b1111, 4'b1111, 1'b1, "R2");
        go(4'b1111, 4'b0000, 1'b0, "R3");
        // R8 / R10: redirect an idle thread, others keep their PCs
        step(4'b0111, 4'b0000, 1'b0, 1'b1, 3, 12'h800, "R10");
        for (int i = 0; i < 3; i++) go(4'b0111, 4'b0000, 1'b0, "R10");
        go(4'b1000, 4'b0000, 1'b0, "R8");
        // R8: redirect the thread granted in the same cycle
        step(4'b1000, 4'b0000, 1'b0, 1'b1, 3, 12'h3C0, "R8");
        go(4'b1000, 4'b0000, 1'b0, "R8");
        // R5: coarse hold
        for (int i = 0; i < 5; i++) go(4'b1111, 4'b0000, 1'b1, "R5");
        // R6: stall moves the grant, wraps past the top index
        go(4'b1111, 4'b1000, 1'b1, "R6");
        go(4'b1111, 4'b1001, 1'b1, "R6");
        go(4'b1111, 4'b1011, 1'b1, "R6");
        go(4'b1111, 4'b0000, 1'b1, "R5");
        go(4'b1011, 4'b0000, 1'b1, "R6");
        go(4'b1111, 4'b1111, 1'b1, "R6");
        // R7: long hold wraps the PC modulo 2^PW
        for (int i = 0; i < 270; i++) go(4'b1111, 4'b0000, 1'b1, "R7");
        go(4'b1111, 4'b0000, 1'b0, "R4");

        wait (sb_q.size() == 0);
        @(posedge clk);
        #2;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule